// File: doc/BRIEF.md
# Nearest-Neighbour Filter Coefficient Loader

This block fills one coefficient set of a polyphase scaler filter so that the filter acts as a nearest-neighbour (pixel-replicating) scaler. The filter has 17 phases of 7 taps each, which makes 119 coefficients of 16 bits. The coefficient store is reached through a pair of registers. One is an index register with an auto-increment enable. The other is a data port, and each write to it stores one 32-bit word holding two coefficients. In a nearest-neighbour set only the middle tap of each phase carries the unity value `0x0800`. Every other tap carries `0x3000`.

A one-cycle start pulse begins a load, and the sequencer then issues writes with a valid/ready handshake. The first write arms the index register at position 0 with auto-increment enabled. Next come 60 packed data words. The tap count runs continuously across phase boundaries, so a single word can hold the tail of one phase and the head of the next. The last write sets the index register back to 0. A one-cycle done pulse marks the end of the load. The block ignores start pulses while a load is running.

Top module: `nn_coef_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `wrValid` are all low.
- R2: The first write of a load selects the index register (`wrSel` = 0) and carries `0x00000400`: position 0 with the auto-increment enable in bit 10.
- R3: Exactly 60 writes to the data port (`wrSel` = 1) follow the first write. The last of them lands at position 59 of an auto-incrementing store.
- R4: Data word k carries coefficient 2k in bits 15:0 and coefficient 2k+1 in bits 31:16. Coefficient i is `0x0800` when i mod 7 equals 3, and `0x3000` otherwise.
- R5: Word 59 holds coefficient 118 in its low half. Its high half is filled as tap 0 (`0x3000`), so the word is `0x30003000`.
- R6: The final write of a load selects the index register and carries `0x00000000`.
- R7: While `wrValid` is high and `wrReady` is low, `wrValid`, `wrSel` and `wrData` stay unchanged into the next cycle. A write counts only on a cycle where both `wrValid` and `wrReady` are high.
- R8: `done` is high for exactly one cycle, the cycle after the final index write is accepted. `busy` rises the cycle after an accepted start and is low while `done` is high.
- R9: A start pulse that arrives while `busy` is high has no effect. The load still issues exactly 62 writes, and no further write follows its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a load |
| wrReady | input | 1 | Target accepts the write offered this cycle |
| wrValid | output | 1 | A write is offered |
| wrSel | output | 1 | Write target: 0 = index register, 1 = data port |
| wrData | output | 32 | Write data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse after the final index write |

## Verification
A tap counter that slips shows up right away as a misplaced `0x0800` in the next data word. Because the count runs on across phases, every later word is then shifted too, so the stored table differs from the computed pattern from that word onward. An error in the word counter changes the number of data writes. It then appears either as a missing word 59 or as a data write after word 59, and the final index write and `done` arrive early or late. The bench compares every word against a pattern it computes itself, under ready patterns from always-ready to heavily stalled. It also watches for held writes that change while stalled.

// File: rtl/nn_coef_pkg.sv
package nn_coef_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARM    = 2'd1,
    ST_DATA   = 2'd2,
    ST_DISARM = 2'd3
  } loadState_t;

  typedef struct packed {
    logic clear;
    logic advance;
    logic selData;
    logic idxArm;
  } ctrlStrobes_t;

endpackage

// File: rtl/nn_coef_datapath.sv
module nn_coef_datapath
  import nn_coef_pkg::*;
#(
  parameter int NUM_PHASES  = 17,
  parameter int NUM_TAPS    = 7,
  parameter int CENTER_TAP  = 3,
  parameter int COEF_W      = 16,
  parameter int DATA_W      = 32,
  parameter int AUTOINC_BIT = 10,
  parameter logic [COEF_W-1:0] CENTER_VAL = 16'h0800,
  parameter logic [COEF_W-1:0] SIDE_VAL   = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [DATA_W-1:0] wrData,
  output logic              lastWord
);

  localparam int NUM_COEFS = NUM_PHASES * NUM_TAPS;
  localparam int PER_WORD  = DATA_W / COEF_W;
  localparam int NUM_WORDS = (NUM_COEFS + PER_WORD - 1) / PER_WORD;
  localparam int TAP_W     = $clog2(NUM_TAPS);
  localparam int WORD_W    = $clog2(NUM_WORDS);
  localparam logic [TAP_W:0]  TAPS_EXT = (TAP_W+1)'(NUM_TAPS);
  localparam logic [TAP_W:0]  STEP_EXT = (TAP_W+1)'(PER_WORD % NUM_TAPS);
  localparam logic [TAP_W-1:0] CENTER_T = TAP_W'(CENTER_TAP);
  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(NUM_WORDS - 1);
  localparam logic [DATA_W-1:0] IDX_ARM_WORD = DATA_W'(1) << AUTOINC_BIT;

  logic [TAP_W-1:0]  tapBase;
  logic [WORD_W-1:0] wordIdx;
  logic [TAP_W:0]    stepSum;
  logic [TAP_W:0]    stepWrap;
  logic [DATA_W-1:0] dataWord;

  // Next base tap: advance by the lanes per word, wrapped modulo the tap count.
  assign stepSum  = {1'b0, tapBase} + STEP_EXT;
  assign stepWrap = (stepSum >= TAPS_EXT) ? (stepSum - TAPS_EXT) : stepSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapBase <= '0;
      wordIdx <= '0;
    end else if (strobes.clear) begin
      tapBase <= '0;
      wordIdx <= '0;
    end else if (strobes.advance) begin
      tapBase <= stepWrap[TAP_W-1:0];
      wordIdx <= wordIdx + 1'b1;
    end
  end

  // One lane per packed coefficient; lane 0 sits in the low bits.
  for (genvar lane = 0; lane < PER_WORD; lane++) begin : g_lane
    localparam logic [TAP_W:0] LANE_OFF = (TAP_W+1)'(lane % NUM_TAPS);
    logic [TAP_W:0]    laneSum;
    logic [TAP_W:0]    laneWrap;
    logic [TAP_W-1:0]  laneTap;
    logic [COEF_W-1:0] laneCoef;

    assign laneSum  = {1'b0, tapBase} + LANE_OFF;
    assign laneWrap = (laneSum >= TAPS_EXT) ? (laneSum - TAPS_EXT) : laneSum;
    assign laneTap  = laneWrap[TAP_W-1:0];
    assign laneCoef = (laneTap == CENTER_T) ? CENTER_VAL : SIDE_VAL;
    assign dataWord[lane*COEF_W +: COEF_W] = laneCoef;
  end

  if (PER_WORD * COEF_W < DATA_W) begin : g_pad
    assign dataWord[DATA_W-1:PER_WORD*COEF_W] = '0;
  end

  always_comb begin
    if (strobes.selData)     wrData = dataWord;
    else if (strobes.idxArm) wrData = IDX_ARM_WORD;
    else                     wrData = '0;
  end

  assign lastWord = (wordIdx == LAST_IDX);

  // R4: the base tap never leaves the legal range.
  a_r4_tap_range: assert property (@(posedge clk) disable iff (!rstN)
    tapBase < TAP_W'(NUM_TAPS));

  // R3: the word counter is never stepped beyond the final word.
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |-> (wordIdx < LAST_IDX));

  // R3: a fresh load restarts from word 0.
  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (wordIdx == '0));

endmodule

// File: rtl/nn_coef_control.sv
module nn_coef_control
  import nn_coef_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wrReady,
  input  logic         lastWord,
  output ctrlStrobes_t strobes,
  output logic         wrValid,
  output logic         busy,
  output logic         done
);

  loadState_t state;
  loadState_t stateNext;
  logic       accept;
  logic       doneQ;

  assign wrValid = (state != ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign accept  = wrValid && wrReady;
  assign done    = doneQ;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_ARM;
      ST_ARM:    if (accept) stateNext = ST_DATA;
      ST_DATA:   if (accept && lastWord) stateNext = ST_DISARM;
      ST_DISARM: if (accept) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.clear   = (state == ST_IDLE) && start;
    strobes.advance = (state == ST_DATA) && accept && !lastWord;
    strobes.selData = (state == ST_DATA);
    strobes.idxArm  = (state == ST_ARM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (state == ST_DISARM) && accept;
    end
  end

  // R8: completion is a single-cycle pulse.
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: when completion is flagged the sequencer is idle and offers nothing.
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !wrValid));

  // R9: a start while loading does not cut the load short.
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !(state == ST_DISARM && wrReady)) |=> busy);

  // R7: an unaccepted offer stays offered.
  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> wrValid);

endmodule

// File: rtl/nn_coef_loader.sv
module nn_coef_loader
  import nn_coef_pkg::*;
#(
  parameter int NUM_PHASES  = 17,
  parameter int NUM_TAPS    = 7,
  parameter int CENTER_TAP  = 3,
  parameter int COEF_W      = 16,
  parameter int DATA_W      = 32,
  parameter int AUTOINC_BIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wrReady,
  output logic              wrValid,
  output logic              wrSel,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done
);

  ctrlStrobes_t strobes;
  logic         lastWord;

  nn_coef_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .wrReady  (wrReady),
    .lastWord (lastWord),
    .strobes  (strobes),
    .wrValid  (wrValid),
    .busy     (busy),
    .done     (done)
  );

  nn_coef_datapath #(
    .NUM_PHASES  (NUM_PHASES),
    .NUM_TAPS    (NUM_TAPS),
    .CENTER_TAP  (CENTER_TAP),
    .COEF_W      (COEF_W),
    .DATA_W      (DATA_W),
    .AUTOINC_BIT (AUTOINC_BIT)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .lastWord (lastWord)
  );

  assign wrSel = strobes.selData;

  // R7: a stalled write keeps its target and payload.
  a_r7_payload_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrSel) && $stable(wrData)));

  // R2, R6: an index write carries either the arm word or zero.
  a_r2_r6_index_values: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrSel) |-> (wrData == (DATA_W'(1) << AUTOINC_BIT) || wrData == '0));

endmodule

// File: tb/nn_coef_loader_tb.sv
module nn_coef_loader_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wrReady = 1'b0;
  logic        wrValid;
  logic        wrSel;
  logic [31:0] wrData;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nn_coef_loader dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .wrReady (wrReady),
    .wrValid (wrValid),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .busy    (busy),
    .done    (done)
  );

  // Monitor state and behavioural coefficient store.
  int          readyMode = 0;
  int          cycle = 0;
  int          xferCount = 0;
  int          lastXferCycle = -1;
  int          doneCycle = -1;
  int          doneCount = 0;
  int          holdErr = 0;
  logic        logSel  [0:127];
  logic [31:0] logData [0:127];
  logic [31:0] mem     [0:127];
  logic [6:0]  memIdx = '0;
  logic        memAuto = 1'b0;
  logic        stallPend = 1'b0;
  logic        stallSel;
  logic [31:0] stallData;

  always @(negedge clk) begin
    logic rdy;
    cycle = cycle + 1;
    if (stallPend) begin
      if (!wrValid || wrSel !== stallSel || wrData !== stallData) holdErr = holdErr + 1;
    end
    case (readyMode)
      0: rdy = 1'b1;
      1: rdy = ($urandom % 2) == 0;
      2: rdy = ($urandom % 4) == 0;
      default: rdy = (cycle % 20) > 14;
    endcase
    wrReady = rdy;
    stallPend = wrValid && !rdy;
    stallSel  = wrSel;
    stallData = wrData;
    if (wrValid && rdy) begin
      if (xferCount < 128) begin
        logSel[xferCount]  = wrSel;
        logData[xferCount] = wrData;
      end
      xferCount = xferCount + 1;
      lastXferCycle = cycle;
      if (!wrSel) begin
        memIdx  = wrData[6:0];
        memAuto = wrData[10];
      end else begin
        mem[memIdx] = wrData;
        if (memAuto) memIdx = memIdx + 1'b1;
      end
    end
    if (done) begin
      doneCount = doneCount + 1;
      doneCycle = cycle;
    end
  end

  function automatic logic [15:0] coefOf(input int i);
    return ((i % 7) == 3) ? 16'h0800 : 16'h3000;
  endfunction

  function automatic logic [31:0] expWord(input int k);
    return {coefOf(2*k + 1), coefOf(2*k)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic doRun(input int mode, input bit injectStart);
    int waitCyc;
    int badWords;
    int firstBad;
    int dataCnt;
    int xfAtDone;
    readyMode = mode;
    xferCount = 0;
    doneCount = 0;
    doneCycle = -1;
    holdErr = 0;
    for (int k = 0; k < 128; k++) mem[k] = '0;
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    check(busy === 1'b1, "R8", "busy after start", {31'd0, busy}, 32'd1);
    waitCyc = 0;
    while (doneCount == 0 && waitCyc < 3000) begin
      if (injectStart && waitCyc == 20) start = 1'b1;
      else start = 1'b0;
      tick();
      waitCyc = waitCyc + 1;
    end
    start = 1'b0;
    check(doneCount == 1, "R8", "done seen before timeout", doneCount, 1);
    xfAtDone = xferCount;
    // R2: arm write
    check(logSel[0] == 1'b0 && logData[0] == 32'h400, "R2", "first write",
          logData[0], 32'h400);
    // R3: data write count and sequence
    dataCnt = 0;
    for (int k = 1; k <= 60; k++) if (logSel[k] == 1'b1) dataCnt = dataCnt + 1;
    check(xfAtDone == 62, "R3", "total writes", xfAtDone, 62);
    check(dataCnt == 60, "R3", "data writes", dataCnt, 60);
    // R4: stored table against computed pattern
    badWords = 0;
    firstBad = 0;
    for (int k = 0; k < 60; k++) begin
      if (mem[k] !== expWord(k)) begin
        if (badWords == 0) firstBad = k;
        badWords = badWords + 1;
      end
    end
    check(badWords == 0, "R4", "table words", mem[firstBad], expWord(firstBad));
    check(mem[1] == 32'h08003000, "R4", "word 1 centre tap", mem[1], 32'h08003000);
    // R5: last word tail
    check(mem[59] == 32'h30003000, "R5", "word 59", mem[59], 32'h30003000);
    check(mem[60] == 32'h0, "R3", "nothing past word 59", mem[60], 32'h0);
    // R6: disarm write
    check(logSel[61] == 1'b0 && logData[61] == 32'h0, "R6", "final write",
          logData[61], 32'h0);
    // R8: timing of done
    check(doneCycle == lastXferCycle + 1, "R8", "done one cycle after last write",
          doneCycle, lastXferCycle + 1);
    check(busy === 1'b0, "R8", "busy low with done", {31'd0, busy}, 32'd0);
    // R7: stalled writes held
    check(holdErr == 0, "R7", "held writes stable", holdErr, 0);
    // R9 / R8: nothing further after done
    for (int c = 0; c < 10; c++) tick();
    check(xferCount == 62, "R9", "no writes after done", xferCount, 62);
    check(doneCount == 1, "R8", "single done pulse", doneCount, 1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    check(busy === 1'b0, "R1", "busy in reset", {31'd0, busy}, 32'd0);
    check(wrValid === 1'b0, "R1", "valid in reset", {31'd0, wrValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) tick();
    check(done === 1'b0 && busy === 1'b0 && wrValid === 1'b0, "R1", "idle after reset",
          {29'd0, done, busy, wrValid}, 32'd0);
    doRun(0, 1'b0);
    doRun(1, 1'b1);
    doRun(2, 1'b0);
    doRun(3, 1'b1);
    doRun(1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule